// File: doc/BRIEF.md
# Baud Tick Generator with Divisor-Selected Prescaler

This block produces the sampling enable for a 16550-style serial port. It runs from a fixed 7.3728 MHz reference clock. Software loads a 16-bit divisor through two byte-wide write strobes, one for the low byte and one for the high byte. The block emits a one-cycle `tick` at sixteen times the selected baud rate. The transmitter and receiver use this tick as their oversampling enable.

The top bit of the divisor is not part of the count. It chooses how the reference is prescaled before the divide counter. When it is clear, the reference is divided by four. When it is set and the per-port high-speed input `hsEnable` is asserted, the reference passes through undivided. Without high-speed enable the bit has no effect. Only the low 15 bits divide, so the divide counter reaches at most 32767.

Any divisor write, or any change of `hsEnable`, restarts both the prescaler and the divide counter. The first tick after a restart therefore comes exactly one full tick period later. In this note, "period" means the number of reference cycles between ticks.

Top module: `baud_tick_gen`

## Requirements
- R1: `tick` is high for single cycles. It repeats every P reference cycles, where P = prescale × (low 15 bits of the divisor). A divisor of 3 with prescale 4 gives a tick lasting one cycle, followed by at least eleven low cycles.
- R2: Only divisor bits 14:0 are counted. With `hsEnable` high and divisor 0xFFFF, the tick period is 32767 cycles.
- R3: Divisor bit 15 (bit 7 of the high byte) selects the prescale. With `hsEnable` high, 0x0001 gives a period of 4 cycles and 0x8001 gives a period of 1 cycle.
- R4: With bit 15 clear, the prescale is 4. Divisor 1 then gives a tick every 4 cycles, which is 1.8432 MHz or 16 × 115200 baud.
- R5: With bit 15 set and `hsEnable` high, the prescale is 1. Divisor 0x8001 then gives a tick every cycle (16 × 460800 baud).
- R6: With `hsEnable` low, bit 15 is ignored. Divisor 0x8001 gives the same 4-cycle period as 0x0001.
- R7: With `hsEnable` high, divisors 0x8002, 0x8003 and 0x8004 give periods of 2, 3 and 4 cycles (230400, 153600 and 115200 baud).
- R8: When divisor bits 14:0 are all zero, no tick is ever produced.
- R9: Reset clears both divisor bytes and the counters, and `tick` stays low until a divisor is written.
- R10: A divisor write, or a change of `hsEnable`, restarts counting. The first tick appears exactly P cycles after the clock edge that sampled the write or the new `hsEnable` level, and no tick occurs before it.
- R11: `wrLo` loads `wrData` into divisor bits 7:0 and `wrHi` loads it into bits 15:8. When both strobes are high together, both bytes take the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7.3728 MHz reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrLo | input | 1 | Write strobe for divisor low byte |
| wrHi | input | 1 | Write strobe for divisor high byte |
| wrData | input | 8 | Byte written to the selected divisor half |
| hsEnable | input | 1 | Per-port high-speed enable from configuration |
| tick | output | 1 | One-cycle enable at 16 × baud rate |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor, a slow prescale of 4 and a fast prescale of 1. With the fast prescale, the largest usable divisor gives a period of only 32767 cycles. This brings the full 15-bit counter range, including its wrap at the maximum, within the run length. The small prescale values let every restart and both prescale settings be compared against the cycle-exact model within a few cycles of each change.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // Strobes sent from the control side to the divide datapath.
  typedef struct packed {
    logic reload;  // restart the divide counter this edge
    logic step;    // one prescaled reference pulse
  } ctrlStrobe_t;

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrLo,
  input  logic                 wrHi,
  input  logic [DIV_W/2-1:0]   wrData,
  input  logic                 hsEnable,
  output logic [DIV_W-2:0]     divCount,
  output logic                 fastSel,
  output ctrlStrobe_t          strobe
);

  localparam int BYTE_W  = DIV_W / 2;
  localparam int PRE_MAX = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PRE_W   = $clog2(PRE_MAX + 1);
  localparam logic [PRE_W-1:0] SLOW_LIM = PRE_W'(SLOW_DIV - 1);
  localparam logic [PRE_W-1:0] FAST_LIM = PRE_W'(FAST_DIV - 1);

  logic [BYTE_W-1:0] divLoQ;
  logic [BYTE_W-1:0] divHiQ;
  logic              hsQ;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preLimit;
  logic              reload;
  logic              preWrap;

  // Restart on any divisor write or any change of the high-speed input.
  assign reload   = wrLo | wrHi | (hsEnable != hsQ);
  assign fastSel  = hsQ & divHiQ[BYTE_W-1];
  assign preLimit = fastSel ? FAST_LIM : SLOW_LIM;
  assign preWrap  = (preCnt == preLimit);
  assign divCount = {divHiQ[BYTE_W-2:0], divLoQ};

  always_comb begin
    strobe        = '0;
    strobe.reload = reload;
    strobe.step   = preWrap & ~reload;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLoQ <= '0;
      divHiQ <= '0;
      hsQ    <= 1'b0;
    end else begin
      if (wrLo) divLoQ <= wrData;
      if (wrHi) divHiQ <= wrData;
      hsQ <= hsEnable;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || reload) begin
      preCnt <= '0;
    end else if (preWrap) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CNT_W-1:0]  divCount,
  output logic              tick
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             tickQ;
  logic             active;
  logic             terminal;

  assign active   = (divCount != '0);
  assign terminal = active && (cnt == divCount - ONE);
  assign tick     = tickQ;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.reload) begin
      cnt   <= '0;
      tickQ <= 1'b0;
    end else begin
      tickQ <= strobe.step & terminal;
      if (strobe.step) begin
        if (terminal || !active) cnt <= '0;
        else                     cnt <= cnt + ONE;
      end
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrLo,
  input  logic               wrHi,
  input  logic [DIV_W/2-1:0] wrData,
  input  logic               hsEnable,
  output logic               tick
);

  localparam int CNT_W = DIV_W - 1;

  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] divCount;
  logic             fastSel;

  baud_ctrl #(
    .DIV_W(DIV_W), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData),
    .hsEnable(hsEnable), .divCount(divCount), .fastSel(fastSel),
    .strobe(strobe)
  );

  baud_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divCount(divCount),
    .tick(tick)
  );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             reload,
  input logic             step,
  input logic             fastSel,
  input logic [CNT_W-1:0] divCount
);

  // R8: a zero divisor never yields a tick
  assert_zero_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (divCount == '0) |-> !tick);

  // R9: reset leaves tick low
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |=> !tick);

  // R10: a restart suppresses any tick on the following cycle
  assert_reload_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> !tick);

  // R4: slow prescale never steps on consecutive cycles
  assert_slow_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!fastSel && step) |=> !step);

  // R1: with the slow prescale the tick is a single-cycle pulse
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!fastSel && tick) |=> !tick);

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.CNT_W(DIV_W - 1)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .reload(strobe.reload),
  .step(strobe.step), .fastSel(fastSel), .divCount(divCount)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrLo = 1'b0;
  logic       wrHi = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       hsEnable = 1'b0;
  logic       tick;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R9";

  always #4 clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rstN(rstN), .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData),
    .hsEnable(hsEnable), .tick(tick)
  );

  // Behavioural reference: divisor bytes, effective mode, cycles since restart
  int mLo = 0, mHi = 0, mSince = 0;
  bit mHs = 0;
  bit expTick = 0;

  function automatic int periodOf(int lo, int hi, bit hs);
    int div = (hi % 128) * 256 + lo;
    int pre = (hi >= 128 && hs) ? 1 : 4;
    return div * pre;
  endfunction

  always @(posedge clk) begin
    int p;
    if (!rstN) begin
      mLo = 0; mHi = 0; mHs = 0; mSince = 0;
    end else if (wrLo || wrHi || hsEnable != mHs) begin
      if (wrLo) mLo = wrData;
      if (wrHi) mHi = wrData;
      mHs = hsEnable;
      mSince = 0;
    end else begin
      mSince++;
    end
    p = periodOf(mLo, mHi, mHs);
    expTick = (p > 0 && mSince > 0 && (mSince % p) == 0);
  end

  always @(negedge clk) begin
    compared++;
    if (tick !== expTick) begin
      mismatched++;
      $display("FAIL %s per-cycle tick=%0b expected=%0b at %0t", curReq, tick, expTick, $time);
    end
  end

  task automatic check(string req, int actual, int expected, string what);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic writeByte(bit lo, bit hi, logic [7:0] d);
    @(negedge clk);
    wrLo = lo; wrHi = hi; wrData = d;
    @(negedge clk);
    wrLo = 0; wrHi = 0;
  endtask

  task automatic setDiv(logic [15:0] d);
    writeByte(1, 0, d[7:0]);
    writeByte(0, 1, d[15:8]);
  endtask

  task automatic setHs(bit v);
    @(negedge clk);
    hsEnable = v;
    @(negedge clk);
  endtask

  // Cycle index (from restart) of the first tick; 0 if none within limit.
  task automatic firstTick(int limit, int expected, string req);
    int found = 0;
    for (int k = 1; k <= limit && found == 0; k++) begin
      @(negedge clk);
      if (tick) found = k;
    end
    check(req, found, expected, "first tick cycle");
  endtask

  task automatic countTicks(int cycles, int expected, string req);
    int n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (tick) n++;
    end
    check(req, n, expected, "tick count");
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    curReq = "R9";
    countTicks(40, 0, "R9");

    curReq = "R4";
    setDiv(16'h0001);
    firstTick(10, 4, "R10");
    countTicks(40, 10, "R4");

    curReq = "R6";
    setDiv(16'h8001);
    firstTick(10, 4, "R6");
    countTicks(40, 10, "R6");

    curReq = "R5";
    setHs(1);
    firstTick(10, 1, "R5");
    countTicks(20, 20, "R5");

    curReq = "R7";
    setDiv(16'h8002);
    firstTick(10, 2, "R7");
    countTicks(20, 10, "R7");
    setDiv(16'h8003);
    firstTick(10, 3, "R7");
    countTicks(30, 10, "R7");
    setDiv(16'h8004);
    firstTick(10, 4, "R7");
    countTicks(40, 10, "R7");

    curReq = "R3";
    setDiv(16'h0001);
    firstTick(10, 4, "R3");
    countTicks(40, 10, "R3");

    curReq = "R10";
    setDiv(16'h8001);
    setHs(0);
    firstTick(10, 4, "R10");
    setHs(1);
    firstTick(10, 1, "R10");

    curReq = "R8";
    setDiv(16'h8000);
    countTicks(200, 0, "R8");
    setHs(0);
    countTicks(50, 0, "R8");

    curReq = "R1";
    setDiv(16'h0003);
    firstTick(20, 12, "R1");
    @(negedge clk);
    check("R1", int'(tick), 0, "tick after pulse");
    countTicks(119, 10, "R1");

    curReq = "R11";
    setHs(1);
    writeByte(1, 1, 8'h02);
    firstTick(3000, 2056, "R11");

    curReq = "R2";
    setDiv(16'hFFFF);
    firstTick(33000, 32767, "R2");
    firstTick(33000, 32767, "R2");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule